// File: doc/BRIEF.md
# Block-Matching Motion Estimator

This block finds how far one square block of pixels from the previous frame has moved in the current frame. It reads the block and a surrounding search window from two pixel memories that the requester has already loaded. For every candidate offset within a configurable ± range it forms the sum of absolute pixel differences (SAD). It then reports the offset with the smallest SAD, and that SAD, as a signed motion vector.

A row of 2·RANGE+1 processing elements works on all horizontal offsets of one vertical offset at once. Each cycle the block fetches one block pixel and the window pixels beside it. Every element adds its own absolute difference to its accumulator. When a row of candidates is complete, a scan stage compares the accumulators one by one against the best result found so far. A requester pulses `start`, waits for the single-cycle `done`, and reads the held vector.

Top module: `me_sad_top`

## Requirements
- R1: After reset, `busy` and `done` are low and `mv_dx`, `mv_dy` and `best_sad` read zero.
- R2: A `start` pulse while idle begins a search, and `busy` is high from the next cycle until the search completes.
- R3: A `start` pulse while `busy` is high is ignored. The running search finishes at its original time with its original result, and no second search follows.
- R4: `done` is high for exactly one cycle, with `busy` low in that cycle. The reported vector and SAD then hold until the next accepted start.
- R5: The reported `best_sad` is the minimum SAD over all (2·RANGE+1)² candidate offsets, and the vector is an offset that attains it.
- R6: Among offsets with equal SAD, the one with the smallest |dx|+|dy| is reported.
- R7: Among offsets with equal SAD and equal |dx|+|dy|, the one first in raster order is reported: smallest dy first, then smallest dx.
- R8: `mv_dx` and `mv_dy` are two's complement in [−RANGE, RANGE]. Candidate (dx,dy) pairs block pixel (r,c) with window pixel (r+dy+RANGE, c+dx+RANGE), so positive dx means rightward and positive dy means downward.
- R9: The SAD accumulator never wraps, even when every pixel difference is 2^PIX_W−1.
- R10: Block pixel (r,c) is requested at `ref_addr` = r·BLK+c. The window request is row `win_row` and base column `win_col`, and lane k of `win_pix` (bits k·PIX_W upward) holds column `win_col`+k. Both memories answer one cycle after the address.
- R11: A search takes exactly (2·RANGE+1)·(BLK²+2·RANGE+2) cycles from the edge that accepts `start` to the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search (taken only while idle) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| ref_addr | output | $clog2(BLK²) | Block pixel read address |
| ref_pix | input | PIX_W | Block pixel read data |
| win_row | output | $clog2(BLK+2·RANGE) | Window row to read |
| win_col | output | $clog2(BLK+2·RANGE) | First window column to read |
| win_pix | input | (2·RANGE+1)·PIX_W | Window pixels at columns win_col..win_col+2·RANGE |
| mv_dx | output | $clog2(RANGE+1)+1 | Signed horizontal displacement |
| mv_dy | output | $clog2(RANGE+1)+1 | Signed vertical displacement |
| best_sad | output | $clog2(BLK²·(2^PIX_W−1)+1) | SAD of the reported offset |

## Verification
The hardest situation to reach from the ports is a tie between distinct offsets. Random pixels almost never produce one, yet the tie rules decide the answer. The stimulus plants exact copies of the block at two disjoint window positions. In one case both copies have the same displacement magnitude, which exercises the raster rule. In the other, the raster-first copy is farther away, which exercises the magnitude rule. Extra random jobs use pixels drawn from only four levels, so that accidental ties appear in many candidates.

// File: rtl/me_pkg.sv
package me_pkg;
    typedef enum logic [1:0] {
        ME_IDLE,
        ME_ACC,
        ME_DRAIN,
        ME_SCAN
    } me_state_t;
endpackage

// File: rtl/me_pe.sv
module me_pe #(
    parameter int PIX_W = 8,
    parameter int SADW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [SADW-1:0]  acc
);
    logic [SADW-1:0]  acc_d, acc_q;
    logic [PIX_W-1:0] dif;

    always_comb begin
        dif   = (a > b) ? (a - b) : (b - a);
        acc_d = acc_q;
        if (clr)
            acc_d = '0;
        else if (en)
            acc_d = acc_q + SADW'(dif);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R9
    acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/me_pick.sv
module me_pick #(
    parameter int SADW = 16,
    parameter int VW   = 4,
    parameter int MW   = 4
) (
    input  logic                  first,
    input  logic [SADW-1:0]       cand_sad,
    input  logic signed [VW-1:0]  cand_dx,
    input  logic signed [VW-1:0]  cand_dy,
    input  logic [SADW-1:0]       best_sad,
    input  logic [MW-1:0]         best_mag,
    output logic                  take,
    output logic [MW-1:0]         cand_mag
);
    logic [VW-1:0] adx, ady;

    always_comb begin
        adx      = cand_dx[VW-1] ? VW'(-cand_dx) : VW'(cand_dx);
        ady      = cand_dy[VW-1] ? VW'(-cand_dy) : VW'(cand_dy);
        cand_mag = MW'(adx) + MW'(ady);
        // candidates arrive in raster order, so an exact tie keeps the older one
        take = first
            || (cand_sad < best_sad)
            || ((cand_sad == best_sad) && (cand_mag < best_mag));
    end
endmodule

// File: rtl/me_sad_top.sv
module me_sad_top
    import me_pkg::*;
#(
    parameter int BLK   = 16,
    parameter int RANGE = 16,
    parameter int PIX_W = 8,
    localparam int NPE  = 2 * RANGE + 1,
    localparam int NPIX = BLK * BLK,
    localparam int RAW  = $clog2(NPIX),
    localparam int WS   = BLK + 2 * RANGE,
    localparam int ROWW = $clog2(WS),
    localparam int KW   = $clog2(NPE),
    localparam int VW   = $clog2(RANGE + 1) + 1,
    localparam int MW   = $clog2(NPE),
    localparam int SADW = $clog2(NPIX * ((1 << PIX_W) - 1) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [RAW-1:0]          ref_addr,
    input  logic [PIX_W-1:0]        ref_pix,
    output logic [ROWW-1:0]         win_row,
    output logic [ROWW-1:0]         win_col,
    input  logic [NPE*PIX_W-1:0]    win_pix,
    output logic signed [VW-1:0]    mv_dx,
    output logic signed [VW-1:0]    mv_dy,
    output logic [SADW-1:0]         best_sad
);
    typedef struct packed {
        me_state_t          st;
        logic [RAW-1:0]     p;
        logic [KW-1:0]      row;
        logic [KW-1:0]      k;
        logic               vld;
        logic               first;
        logic [SADW-1:0]    bsad;
        logic [MW-1:0]      bmag;
        logic signed [VW-1:0] bdx;
        logic signed [VW-1:0] bdy;
        logic               done;
        logic signed [VW-1:0] odx;
        logic signed [VW-1:0] ody;
        logic [SADW-1:0]    osad;
    } regs_t;

    regs_t r_d, r_q;
    logic  clr;
    logic  take;
    logic [MW-1:0]        cand_mag;
    logic [SADW-1:0]      cand_sad;
    logic signed [VW-1:0] cand_dx, cand_dy;
    logic [SADW-1:0]      acc_all [NPE];

    genvar gi;
    generate
        for (gi = 0; gi < NPE; gi++) begin : g_pe
            me_pe #(.PIX_W(PIX_W), .SADW(SADW)) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .en    (r_q.vld),
                .a     (ref_pix),
                .b     (win_pix[gi*PIX_W +: PIX_W]),
                .acc   (acc_all[gi])
            );
        end
    endgenerate

    assign cand_sad = acc_all[r_q.k];
    assign cand_dx  = VW'(r_q.k) - VW'(RANGE);
    assign cand_dy  = VW'(r_q.row) - VW'(RANGE);

    me_pick #(.SADW(SADW), .VW(VW), .MW(MW)) u_pick (
        .first    (r_q.first),
        .cand_sad (cand_sad),
        .cand_dx  (cand_dx),
        .cand_dy  (cand_dy),
        .best_sad (r_q.bsad),
        .best_mag (r_q.bmag),
        .take     (take),
        .cand_mag (cand_mag)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.vld  = (r_q.st == ME_ACC);
        clr      = 1'b0;
        unique case (r_q.st)
            ME_IDLE: begin
                if (start) begin
                    r_d.st    = ME_ACC;
                    r_d.p     = '0;
                    r_d.row   = '0;
                    r_d.first = 1'b1;
                    clr       = 1'b1;
                end
            end
            ME_ACC: begin
                r_d.p = r_q.p + 1'b1;
                if (r_q.p == RAW'(NPIX - 1))
                    r_d.st = ME_DRAIN;
            end
            ME_DRAIN: begin
                r_d.st = ME_SCAN;
                r_d.k  = '0;
            end
            ME_SCAN: begin
                if (take) begin
                    r_d.bsad  = cand_sad;
                    r_d.bmag  = cand_mag;
                    r_d.bdx   = cand_dx;
                    r_d.bdy   = cand_dy;
                    r_d.first = 1'b0;
                end
                r_d.k = r_q.k + 1'b1;
                if (r_q.k == KW'(NPE - 1)) begin
                    if (r_q.row == KW'(NPE - 1)) begin
                        r_d.st   = ME_IDLE;
                        r_d.done = 1'b1;
                        r_d.odx  = r_d.bdx;
                        r_d.ody  = r_d.bdy;
                        r_d.osad = r_d.bsad;
                    end else begin
                        r_d.st  = ME_ACC;
                        r_d.row = r_q.row + 1'b1;
                        r_d.p   = '0;
                        clr     = 1'b1;
                    end
                end
            end
            default: r_d.st = ME_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ME_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ME_IDLE);
    assign done     = r_q.done;
    assign ref_addr = r_q.p;
    assign win_row  = ROWW'(r_q.p / BLK) + ROWW'(r_q.row);
    assign win_col  = ROWW'(r_q.p % BLK);
    assign mv_dx    = r_q.odx;
    assign mv_dy    = r_q.ody;
    assign best_sad = r_q.osad;

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(mv_dx) && $stable(mv_dy) && $stable(best_sad)));
    // R8
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mv_dx >= -VW'(RANGE)) && (mv_dx <= VW'(RANGE))
               && (mv_dy >= -VW'(RANGE)) && (mv_dy <= VW'(RANGE))));
    // R5
    best_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ME_SCAN && !r_q.first) |=> (r_q.bsad <= $past(r_q.bsad)));
endmodule

// File: tb/sim_me_sad_top.sv
module sim_me_sad_top;
    localparam int BLK   = 8;
    localparam int RANGE = 4;
    localparam int PIX_W = 8;
    localparam int NPE   = 2 * RANGE + 1;
    localparam int NPIX  = BLK * BLK;
    localparam int WS    = BLK + 2 * RANGE;
    localparam int RAW   = $clog2(NPIX);
    localparam int ROWW  = $clog2(WS);
    localparam int VW    = $clog2(RANGE + 1) + 1;
    localparam int SADW  = $clog2(NPIX * ((1 << PIX_W) - 1) + 1);
    localparam int LAT   = NPE * (NPIX + 2 * RANGE + 2);
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done;
    logic [RAW-1:0] ref_addr;
    logic [PIX_W-1:0] ref_pix;
    logic [ROWW-1:0] win_row, win_col;
    logic [NPE*PIX_W-1:0] win_pix;
    logic signed [VW-1:0] mv_dx, mv_dy;
    logic [SADW-1:0] best_sad;

    logic [PIX_W-1:0] refm [NPIX];
    logic [PIX_W-1:0] winm [WS][WS];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_dx, exp_dy, exp_sad;

    always #(CLK_PERIOD/2) clk = ~clk;

    me_sad_top #(.BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .ref_addr(ref_addr), .ref_pix(ref_pix), .win_row(win_row), .win_col(win_col),
        .win_pix(win_pix), .mv_dx(mv_dx), .mv_dy(mv_dy), .best_sad(best_sad)
    );

    // memories with one cycle of read latency (R10)
    always_ff @(posedge clk) begin
        ref_pix <= refm[ref_addr];
        for (int k = 0; k < NPE; k++)
            win_pix[k*PIX_W +: PIX_W] <= winm[win_row][int'(win_col) + k];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural model: raster scan, strict improvement on SAD or magnitude
    task automatic model();
        int bs, bm;
        bs = -1; bm = 0;
        for (int dy = -RANGE; dy <= RANGE; dy++)
            for (int dx = -RANGE; dx <= RANGE; dx++) begin
                int s, m;
                s = 0;
                for (int r = 0; r < BLK; r++)
                    for (int c = 0; c < BLK; c++) begin
                        int a, b;
                        a = refm[r*BLK + c];
                        b = winm[r + dy + RANGE][c + dx + RANGE];
                        s += (a > b) ? a - b : b - a;
                    end
                m = (dx < 0 ? -dx : dx) + (dy < 0 ? -dy : dy);
                if (bs < 0 || s < bs || (s == bs && m < bm)) begin
                    bs = s; bm = m; exp_dx = dx; exp_dy = dy;
                end
            end
        exp_sad = bs;
    endtask

    task automatic fill_random(input int maxv);
        for (int i = 0; i < NPIX; i++) refm[i] = PIX_W'($urandom_range(maxv, 0));
        for (int r = 0; r < WS; r++)
            for (int c = 0; c < WS; c++) winm[r][c] = PIX_W'($urandom_range(maxv, 0));
    endtask

    task automatic plant(input int dx, input int dy);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++)
                winm[r + dy + RANGE][c + dx + RANGE] = refm[r*BLK + c];
    endtask

    task automatic run_job(input string req, input bit poke);
        int cnt;
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        cnt = 1;
        while (!done && cnt < 4 * LAT) begin
            if (poke && cnt == 100) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        check(cnt == LAT + 1, poke ? "R3" : "R11", "cycles to done", cnt, LAT + 1);
        check(int'(mv_dx) == exp_dx, req, "mv_dx", int'(mv_dx), exp_dx);
        check(int'(mv_dy) == exp_dy, req, "mv_dy", int'(mv_dy), exp_dy);
        check(int'(best_sad) == exp_sad, req, "best_sad", int'(best_sad), exp_sad);
        check(busy == 1'b0, "R4", "busy with done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R4", "done width", int'(done), 0);
        if (poke) begin
            bit again = 1'b0;
            repeat (LAT + 5) begin
                @(negedge clk);
                if (done || busy) again = 1'b1;
            end
            check(!again, "R3", "no second search", int'(again), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NPIX; i++) refm[i] = '0;
        for (int r = 0; r < WS; r++)
            for (int c = 0; c < WS; c++) winm[r][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done", int'({busy, done}), 0);
        check(mv_dx == 0 && mv_dy == 0, "R1", "vector", int'(mv_dx) + int'(mv_dy), 0);
        check(best_sad == 0, "R1", "sad", int'(best_sad), 0);

        // all-zero: every offset ties, nearest wins (R6)
        run_job("R6", 1'b0);

        // maximum contrast: no wrap, all tie at full sum (R9)
        for (int i = 0; i < NPIX; i++) refm[i] = '1;
        run_job("R9", 1'b0);

        // exact copy at an interior offset, also proves lane/row mapping (R8, R10)
        fill_random(255); plant(3, -2);
        run_job("R8", 1'b0);
        fill_random(255); plant(-RANGE, -RANGE);
        run_job("R8", 1'b0);
        fill_random(255); plant(RANGE, RANGE);
        run_job("R10", 1'b0);

        // equal SAD, equal magnitude: raster first picks (-4,0) (R7)
        fill_random(255); plant(-RANGE, 0); plant(RANGE, 0);
        run_job("R7", 1'b0);
        check(int'(mv_dx) == -RANGE, "R7", "raster tie dx", int'(mv_dx), -RANGE);

        // equal SAD, smaller magnitude later in raster wins (R6)
        fill_random(255); plant(-RANGE, -RANGE); plant(RANGE, 0);
        run_job("R6", 1'b0);

        // start pulses during busy are ignored (R3)
        fill_random(255); plant(1, 2);
        run_job("R3", 1'b1);

        // result held while idle (R4)
        begin
            int hx, hy, hs;
            hx = int'(mv_dx); hy = int'(mv_dy); hs = int'(best_sad);
            fill_random(255);
            repeat (20) @(negedge clk);
            check(int'(mv_dx) == hx && int'(mv_dy) == hy && int'(best_sad) == hs,
                  "R4", "held sad", int'(best_sad), hs);
        end

        // random jobs, some with few pixel levels to provoke ties (R5)
        for (int j = 0; j < 14; j++) begin
            fill_random((j % 2 == 0) ? 3 : 255);
            if (j % 3 == 0) plant($urandom_range(2*RANGE, 0) - RANGE,
                                  $urandom_range(2*RANGE, 0) - RANGE);
            run_job("R5", 1'b0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule